// File: doc/BRIEF.md
# Element-wise Matrix Addition Sequencer

This block sums two matrices of identical shape, element by element, using signed fixed-point arithmetic. Both operand matrices sit one after the other in an external word-addressed memory. The block fetches them one word at a time through a request/valid read port and stages them in two on-chip simple dual-port buffers. It then adds matching entries, keeps each sum in place of the first operand, and writes the results to a separate result region of the same memory through a request/ready write port.

A single start pulse launches the whole job. The phases always run in the same order: fetch operand A, fetch operand B, add, write out, finish. When the last result word has been accepted, a done level rises and stays high until the next start pulse launches a new job. The matrix shape (COLS by ROWS), the element width and the number of fractional bits are parameters. The fractional width does not change the arithmetic, because fixed-point addition is the same as plain integer addition.

Top module: `matadd_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `done`, `rd_req` and `wr_req` are all 0, and with no start pulse the block issues no request.
- R2: After start, the block reads external addresses 0 through 2*N-1 (N = COLS*ROWS) in ascending order. It has at most one read outstanding: `rd_req` is high for one cycle, and it is not raised again until the matching `rd_valid` has arrived.
- R3: The first N words returned are taken as operand A, element i being word i. The next N words are taken as operand B, element i being word N+i.
- R4: Result element i equals A[i] + B[i] modulo 2^DW (two's complement wrap). There is no saturation, so MAX+1 gives MIN and MIN+(-1) gives MAX.
- R5: Exactly N result writes are made, to addresses RES_BASE+0 through RES_BASE+N-1 in ascending order. While `wr_req` is high and `wr_ready` is low, `wr_addr` and `wr_data` stay unchanged.
- R6: Any `rd_valid` delay of one or more cycles after the request is tolerated, and the results do not depend on it.
- R7: `done` rises in the cycle right after the final write is accepted. It stays high, with no requests issued, until a start pulse arrives. The cycle after that pulse, `done` is 0.
- R8: A start pulse that arrives while a job is running has no effect: the job's reads, writes and results are unchanged.
- R9: Every read address lies in [0, 2*N), and every write address lies in [RES_BASE, RES_BASE+N).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that launches a job from idle or from done |
| done | output | 1 | High from job completion until the next start |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | AW | Word address of the read request |
| rd_valid | input | 1 | One-cycle flag that read data is present |
| rd_data | input | DW | Returned read word |
| wr_req | output | 1 | Write request, held until accepted |
| wr_addr | output | AW | Write word address |
| wr_data | output | DW | Write data (signed fixed point) |
| wr_ready | input | 1 | Write accepted in a cycle where wr_req is also high |

## Verification
The assertions take for granted that the memory side raises `rd_valid` only for a read that is outstanding, for exactly one cycle, and never in the same cycle as the request. They also take for granted that `wr_ready` has meaning only while `wr_req` is high. The stimulus model keeps within these rules: it answers each request once, after a delay of 1 to 5 cycles that changes from word to word. It drives `wr_ready` only in cycles where a write is pending, and lowers it every third such cycle so that the hold rule is exercised. Operand patterns include values at the edge of the range, chosen to force a wrap in both directions.

// File: rtl/matadd_pkg.sv
package matadd_pkg;
   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_LOAD_A = 3'd1,
      PH_LOAD_B = 3'd2,
      PH_ADD    = 3'd3,
      PH_STORE  = 3'd4,
      PH_DONE   = 3'd5
   } phase_t;
endpackage

// File: rtl/matadd_sdp_buf.sv
// Simple dual-port staging buffer: one write port, one read port, one-cycle
// read latency. The read output holds its value while no read is issued.
module matadd_sdp_buf #(
   parameter int DW    = 64,
   parameter int DEPTH = 32,
   parameter int BAW   = 5
) (
   input  logic           clk,
   input  logic           we,
   input  logic [BAW-1:0] waddr,
   input  logic [DW-1:0]  wdata,
   input  logic           re,
   input  logic [BAW-1:0] raddr,
   output logic [DW-1:0]  rdata
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("matadd_sdp_buf: DEPTH must be at least 1");
   end
   if ((1 << BAW) < DEPTH) begin : g_bad_baw
      $error("matadd_sdp_buf: BAW too narrow for DEPTH");
   end

   logic [DW-1:0] store_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         store_q[waddr] <= wdata;
      end
      if (re) begin
         rdata <= store_q[raddr];
      end
   end
endmodule

// File: rtl/matadd_wrap_add.sv
// Signed fixed-point adder. Both operands share one binary point, so the sum
// is a plain modular addition; overflow wraps in two's complement.
module matadd_wrap_add #(
   parameter int DW   = 64,
   parameter int FRAC = 15
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   output logic [DW-1:0] sum
);
   if (FRAC < 0 || FRAC >= DW) begin : g_bad_frac
      $error("matadd_wrap_add: FRAC must lie in [0, DW)");
   end

   always_comb begin
      sum = a + b;
   end
endmodule

// File: rtl/matadd_seq.sv
module matadd_seq #(
   parameter int COLS     = 8,
   parameter int ROWS     = 4,
   parameter int DW       = 64,
   parameter int FRAC     = 15,
   parameter int AW       = 16,
   parameter int RES_BASE = 2 * COLS * ROWS
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          done,
   output logic          rd_req,
   output logic [AW-1:0] rd_addr,
   input  logic          rd_valid,
   input  logic [DW-1:0] rd_data,
   output logic          wr_req,
   output logic [AW-1:0] wr_addr,
   output logic [DW-1:0] wr_data,
   input  logic          wr_ready
);
   import matadd_pkg::*;

   localparam int N   = COLS * ROWS;
   localparam int BAW = (N > 1) ? $clog2(N) : 1;
   localparam logic [BAW-1:0] LAST_IDX = BAW'(N - 1);
   localparam logic [AW-1:0]  B_OFFSET = AW'(N);
   localparam logic [AW-1:0]  RES_OFF  = AW'(RES_BASE);

   if (COLS < 1 || ROWS < 1) begin : g_bad_shape
      $error("matadd_seq: COLS and ROWS must be positive");
   end
   if (DW < 2) begin : g_bad_dw
      $error("matadd_seq: DW must be at least 2");
   end
   if (AW < 1 || AW > 31 || (2 * N) > (1 << AW) || (RES_BASE + N) > (1 << AW)) begin : g_bad_aw
      $error("matadd_seq: AW cannot address operands and results");
   end
   if (RES_BASE < 2 * N) begin : g_bad_base
      $error("matadd_seq: result region overlaps the operand region");
   end

   phase_t         ph;
   logic [BAW-1:0] cnt;
   logic           rd_pend;
   logic           add_issued;
   logic           st_hold;
   logic           wb_we;
   logic           wb_last;
   logic [BAW-1:0] wb_addr;

   logic           at_last;
   logic           in_load;
   logic           rd_take;
   logic           add_rd;
   logic           st_fetch;
   logic           wr_take;
   logic [DW-1:0]  sum;

   // per-buffer port bundles, index 0 = operand A / result, 1 = operand B
   logic           b_we    [2];
   logic [BAW-1:0] b_waddr [2];
   logic [DW-1:0]  b_wdata [2];
   logic           b_re    [2];
   logic [DW-1:0]  b_rdata [2];

   always_comb begin
      at_last  = (cnt == LAST_IDX);
      in_load  = (ph == PH_LOAD_A) || (ph == PH_LOAD_B);
      rd_take  = in_load && rd_pend && rd_valid;
      add_rd   = (ph == PH_ADD) && !add_issued;
      st_fetch = (ph == PH_STORE) && !st_hold;
      wr_take  = wr_req && wr_ready;
   end

   // external port drive
   always_comb begin
      rd_req  = in_load && !rd_pend;
      rd_addr = AW'(cnt) + ((ph == PH_LOAD_B) ? B_OFFSET : '0);
      wr_req  = (ph == PH_STORE) && st_hold;
      wr_addr = RES_OFF + AW'(cnt);
      wr_data = b_rdata[0];
      done    = (ph == PH_DONE);
   end

   // buffer port steering: buffer 0 takes loads of A and the write-back of
   // sums (aligned one cycle behind the read), buffer 1 takes loads of B
   always_comb begin
      b_we[0]    = ((ph == PH_LOAD_A) && rd_take) || wb_we;
      b_waddr[0] = wb_we ? wb_addr : cnt;
      b_wdata[0] = wb_we ? sum : rd_data;
      b_re[0]    = add_rd || st_fetch;
      b_we[1]    = (ph == PH_LOAD_B) && rd_take;
      b_waddr[1] = cnt;
      b_wdata[1] = rd_data;
      b_re[1]    = add_rd;
   end

   for (genvar gi = 0; gi < 2; gi++) begin : g_buf
      matadd_sdp_buf #(
         .DW    (DW),
         .DEPTH (N),
         .BAW   (BAW)
      ) u_buf (
         .clk   (clk),
         .we    (b_we[gi]),
         .waddr (b_waddr[gi]),
         .wdata (b_wdata[gi]),
         .re    (b_re[gi]),
         .raddr (cnt),
         .rdata (b_rdata[gi])
      );
   end

   matadd_wrap_add #(
      .DW   (DW),
      .FRAC (FRAC)
   ) u_add (
      .a   (b_rdata[0]),
      .b   (b_rdata[1]),
      .sum (sum)
   );

   // write-back alignment: the sum appears one cycle after its read
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wb_we   <= 1'b0;
         wb_last <= 1'b0;
         wb_addr <= '0;
      end else begin
         wb_we   <= add_rd;
         wb_last <= add_rd && at_last;
         wb_addr <= cnt;
      end
   end

   // phase sequencing
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph         <= PH_IDLE;
         cnt        <= '0;
         rd_pend    <= 1'b0;
         add_issued <= 1'b0;
         st_hold    <= 1'b0;
      end else begin
         unique case (ph)
            PH_IDLE, PH_DONE: begin
               if (start) begin
                  ph      <= PH_LOAD_A;
                  cnt     <= '0;
                  rd_pend <= 1'b0;
               end
            end
            PH_LOAD_A, PH_LOAD_B: begin
               if (rd_req) begin
                  rd_pend <= 1'b1;
               end
               if (rd_take) begin
                  rd_pend <= 1'b0;
                  if (at_last) begin
                     cnt        <= '0;
                     add_issued <= 1'b0;
                     ph         <= (ph == PH_LOAD_A) ? PH_LOAD_B : PH_ADD;
                  end else begin
                     cnt <= cnt + BAW'(1);
                  end
               end
            end
            PH_ADD: begin
               if (add_rd) begin
                  if (at_last) begin
                     add_issued <= 1'b1;
                  end else begin
                     cnt <= cnt + BAW'(1);
                  end
               end
               if (wb_last) begin
                  ph      <= PH_STORE;
                  cnt     <= '0;
                  st_hold <= 1'b0;
               end
            end
            PH_STORE: begin
               if (st_fetch) begin
                  st_hold <= 1'b1;
               end
               if (wr_take) begin
                  st_hold <= 1'b0;
                  if (at_last) begin
                     ph <= PH_DONE;
                  end else begin
                     cnt <= cnt + BAW'(1);
                  end
               end
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/matadd_seq_chk.sv
module matadd_seq_chk #(
   parameter int AW       = 16,
   parameter int DW       = 64,
   parameter int N        = 32,
   parameter int RES_BASE = 64
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          done,
   input logic          rd_req,
   input logic [AW-1:0] rd_addr,
   input logic          wr_req,
   input logic [AW-1:0] wr_addr,
   input logic [DW-1:0] wr_data,
   input logic          wr_ready
);
   localparam logic [AW-1:0] RD_LIM = AW'(2 * N);
   localparam logic [AW-1:0] WR_LO  = AW'(RES_BASE);
   localparam logic [AW-1:0] WR_HI  = AW'(RES_BASE + N);

   assert_single_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> !rd_req);

   assert_rd_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> (rd_addr < RD_LIM));

   assert_wr_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |-> ((wr_addr >= WR_LO) && (wr_addr < WR_HI)));

   assert_wr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wr_ready) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

   assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!rd_req && !wr_req));

   assert_done_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(wr_req && wr_ready));

   assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);

   assert_start_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && start) |=> !done);
endmodule

bind matadd_seq matadd_seq_chk #(
   .AW       (AW),
   .DW       (DW),
   .N        (COLS * ROWS),
   .RES_BASE (RES_BASE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .done     (done),
   .rd_req   (rd_req),
   .rd_addr  (rd_addr),
   .wr_req   (wr_req),
   .wr_addr  (wr_addr),
   .wr_data  (wr_data),
   .wr_ready (wr_ready)
);

// File: tb/matadd_seq_test.sv
`timescale 1ns/1ps
module matadd_seq_test;
   localparam int COLS     = 8;
   localparam int ROWS     = 4;
   localparam int DW       = 64;
   localparam int FRAC     = 15;
   localparam int AW       = 16;
   localparam int N        = COLS * ROWS;
   localparam int RES_BASE = 2 * N;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          done;
   logic          rd_req;
   logic [AW-1:0] rd_addr;
   logic          rd_valid = 1'b0;
   logic [DW-1:0] rd_data = '0;
   logic          wr_req;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;
   logic          wr_ready = 1'b0;

   always #10 clk = ~clk;

   matadd_seq #(
      .COLS(COLS), .ROWS(ROWS), .DW(DW), .FRAC(FRAC), .AW(AW), .RES_BASE(RES_BASE)
   ) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .done(done),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
      .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready)
   );

   int checks = 0;
   int failures = 0;
   int rd_expect = 0;
   int run_seed = 0;
   logic [DW-1:0] mem [3*N];
   logic [AW-1:0] exp_addr_q [$];
   logic [DW-1:0] exp_data_q [$];

   task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // memory read responder: one answer per request, variable delay (R6)
   initial begin
      @(negedge clk);
      forever begin
         if (rst_n && rd_req) begin
            automatic int a = int'(rd_addr);
            automatic int dly = 1 + ((a * 3 + run_seed) % 5);
            check(a == rd_expect, "R2 read order", DW'(a), DW'(rd_expect));
            rd_expect++;
            repeat (dly) @(negedge clk);
            rd_valid = 1'b1;
            rd_data  = (a < 3 * N) ? mem[a] : '0;
            @(negedge clk);
            rd_valid = 1'b0;
         end else begin
            @(negedge clk);
         end
      end
   end

   // write monitor: scoreboard pop and compare
   initial begin
      automatic int tick = 0;
      automatic bit held = 1'b0;
      automatic logic [AW-1:0] pa = '0;
      automatic logic [DW-1:0] pd = '0;
      forever begin
         @(negedge clk);
         if (rst_n && wr_req) begin
            tick++;
            wr_ready = (tick % 3) != 1;
            if (held) begin
               check(wr_addr == pa && wr_data == pd, "R5 held write changed",
                     DW'(wr_addr) ^ wr_data, DW'(pa) ^ pd);
            end
            if (wr_ready) begin
               if (exp_addr_q.size() == 0) begin
                  check(1'b0, "R5 unexpected extra write", DW'(wr_addr), '0);
               end else begin
                  automatic logic [AW-1:0] ea = exp_addr_q.pop_front();
                  automatic logic [DW-1:0] ed = exp_data_q.pop_front();
                  check(wr_addr == ea, "R5 R9 write address", DW'(wr_addr), DW'(ea));
                  check(wr_data == ed, "R3 R4 result value", wr_data, ed);
                  if (exp_addr_q.size() == 0) begin
                     @(negedge clk);
                     wr_ready = 1'b0;
                     check(done == 1'b1, "R7 done right after last write", DW'(done), 1);
                  end
               end
            end
            held = wr_req && !wr_ready;
            pa = wr_addr;
            pd = wr_data;
         end else begin
            wr_ready = 1'b0;
            held = 1'b0;
         end
      end
   end

   // driver: fill memory and push expected results
   task automatic prepare(input int mode);
      logic [DW-1:0] lf = 64'h1234_5678_9abc_def1 ^ DW'(mode);
      logic [DW-1:0] maxv = {1'b0, {(DW-1){1'b1}}};
      logic [DW-1:0] minv = {1'b1, {(DW-1){1'b0}}};
      exp_addr_q.delete();
      exp_data_q.delete();
      for (int i = 0; i < N; i++) begin
         logic [DW-1:0] a;
         logic [DW-1:0] b;
         case (mode)
            0: begin
               a = DW'(i) << FRAC;
               b = DW'(-(i * 3 + 1)) << (FRAC - 1);
            end
            1: begin
               if (i % 2 == 0) begin a = maxv; b = DW'(i + 1); end
               else begin a = minv; b = -DW'(i); end
            end
            2: begin
               lf = {lf[DW-2:0], lf[DW-1] ^ lf[DW-2] ^ lf[DW-4] ^ lf[DW-5]};
               a = lf;
               lf = {lf[DW-2:0], lf[DW-1] ^ lf[DW-2] ^ lf[DW-4] ^ lf[DW-5]};
               b = lf ^ (DW'(i) << 40);
            end
            default: begin
               a = DW'(i * 77);
               b = ~DW'(i * 77);
            end
         endcase
         mem[i] = a;
         mem[N + i] = b;
         exp_addr_q.push_back(AW'(RES_BASE + i));
         exp_data_q.push_back(a + b);
      end
   endtask

   task automatic run_job(input int mode, input bit stray_start, output bit timed_out);
      int waited = 0;
      timed_out = 1'b0;
      prepare(mode);
      run_seed = mode * 2 + 1;
      rd_expect = 0;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(done == 1'b0, "R7 start clears done", DW'(done), 0);
      if (stray_start) begin
         repeat (12) @(negedge clk);
         start = 1'b1;             // R8: ignored while loading
         @(negedge clk);
         start = 1'b0;
      end
      while (!done && waited < 20000) begin
         @(negedge clk);
         waited++;
      end
      if (!done) begin
         check(1'b0, "R7 watchdog expired waiting for done", 0, 1);
         timed_out = 1'b1;
         return;
      end
      repeat (3) @(negedge clk);
      check(exp_addr_q.size() == 0, "R5 all N results written",
            DW'(exp_addr_q.size()), 0);
      check(rd_expect == 2 * N, "R6 R2 all operand words fetched",
            DW'(rd_expect), DW'(2 * N));
      repeat (10) @(negedge clk);
      check(done == 1'b1 && !rd_req && !wr_req, "R7 done holds quietly",
            DW'({done, rd_req, wr_req}), DW'(3'b100));
      if (stray_start) begin
         check(rd_expect == 2 * N, "R8 stray start caused no extra reads",
               DW'(rd_expect), DW'(2 * N));
      end
   endtask

   initial begin
      automatic bit to = 1'b0;
      repeat (5) @(negedge clk);
      check(done == 0 && rd_req == 0 && wr_req == 0, "R1 outputs in reset",
            DW'({done, rd_req, wr_req}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(done == 0 && rd_req == 0 && wr_req == 0, "R1 outputs after reset",
            DW'({done, rd_req, wr_req}), 0);
      repeat (10) @(negedge clk);
      check(rd_req == 0 && rd_expect == 0, "R1 idle without start",
            DW'(rd_req), 0);
      run_job(0, 1'b0, to);
      if (!to) run_job(1, 1'b0, to);   // R4 wrap both directions
      if (!to) run_job(2, 1'b1, to);   // R8 stray start mid-job
      if (!to) run_job(3, 1'b0, to);   // R3 sums of complements
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule